// File: doc/BRIEF.md
# PCI Target Address Decoder

This block watches the shared address/data lines of a PCI bus on behalf of one target. When a new transaction starts, it captures the command, the address and the per-slot configuration select in that single clock. It then decides whether this device owns the access. I/O commands are compared against an I/O window, memory commands against a memory window, and configuration commands are accepted only for a local (Type 0) access that selects this slot. A window is ignored while its decode-enable bit is clear.

A claimed access drives DEVSEL# low one clock later than the fastest possible timing. DEVSEL# is held until the edge that completes the last data phase, or until the bus returns to idle. During the claim, a one-cycle strobe marks every edge on which both the initiator and the target were ready, so data moved. The window bases and enable bits arrive from neighbouring configuration logic. Window sizes are fixed at build time by parameters.

Top module: `pci_tgt_claim`

## Requirements
- R1: While reset is held, and after it is released with the bus idle, `devsel_n` is 1, `xfer_fire` is 0 and `claim_space` is 0.
- R2: The address is captured only on a rising edge where `bus_frame_n` is 0 and the previous rising edge saw both `bus_frame_n` and `bus_irdy_n` at 1. Values on the lines during later edges of the same transaction are never decoded as an address.
- R3: Command codes 0010 (I/O read) and 0011 (I/O write) are claimed when `io_decode_en` is 1 and address bits [ADDR_W-1:IO_IGN_BITS] equal the same bits of `io_win_base`. This includes every bit above 15, even when the base has zeros there. IO_IGN_BITS must lie in 2..8.
- R4: Command codes 0110 (memory read) and 0111 (memory write) are claimed when `mem_decode_en` is 1 and address bits [ADDR_W-1:MEM_IGN_BITS] equal those of `mem_win_base`. MEM_IGN_BITS is at least 4, so address bits [1:0] never affect the result.
- R5: Command codes 1010 and 1011 (configuration read/write) are claimed only when `bus_idsel` is 1 and address bits [1:0] are 00. The value 01 in bits [1:0], or `bus_idsel` at 0, gives no claim. No window compare applies.
- R6: With `io_decode_en` at 0, no I/O command is claimed. With `mem_decode_en` at 0, no memory command is claimed.
- R7: Every other command code is never claimed.
- R8: For a claimed access, `devsel_n` becomes 0 after the second rising edge counted from the address edge (the address edge being the first).
- R9: `devsel_n` returns to 1 after a rising edge where it was 0 and either (a) `bus_frame_n`, `bus_irdy_n` and `bus_trdy_n` are 1, 0 and 0, or (b) `bus_frame_n` and `bus_irdy_n` are both 1.
- R10: `xfer_fire` is 1 for exactly the cycle after a rising edge where `devsel_n` was 0 and both `bus_irdy_n` and `bus_trdy_n` were 0. Otherwise it is 0.
- R11: `claim_space` reads 1 for I/O, 2 for memory and 3 for configuration while `devsel_n` is 0, and 0 whenever `devsel_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_ad | input | ADDR_W | Multiplexed address/data lines |
| bus_cbe_n | input | 4 | Command during address phase, byte enables afterwards |
| bus_frame_n | input | 1 | Initiator transaction framing, active low |
| bus_irdy_n | input | 1 | Initiator ready, active low |
| bus_trdy_n | input | 1 | Target ready, active low |
| bus_idsel | input | 1 | Per-slot configuration select |
| io_win_base | input | ADDR_W | Base of the I/O window |
| mem_win_base | input | ADDR_W | Base of the memory window |
| io_decode_en | input | 1 | Enables I/O decoding |
| mem_decode_en | input | 1 | Enables memory decoding |
| devsel_n | output | 1 | Device select claim, active low |
| claim_space | output | 2 | Space of the current claim: 0 none, 1 I/O, 2 memory, 3 configuration |
| xfer_fire | output | 1 | One-cycle strobe per completed data phase |

## Verification
The bench builds the block with a 16-byte I/O window (IO_IGN_BITS = 4) and a 4 KB memory window (MEM_IGN_BITS = 12), keeping ADDR_W at 32. The small I/O window puts both kinds of I/O miss within a few directed addresses: one with a bit just above the window differing, and one with bit 16 set while the base has zeros above bit 15. The 4 KB memory window lets a burst end at an address with low bits 01 and still match. Configuration accesses are tried with each select/type combination. A data phase that carries a matching memory address and command pattern shows that an address is never sampled twice.

// File: rtl/pci_claim_pkg.sv
package pci_claim_pkg;

   typedef enum logic [1:0] {
      SP_NONE = 2'd0,
      SP_IO   = 2'd1,
      SP_MEM  = 2'd2,
      SP_CFG  = 2'd3
   } space_e;

   localparam logic [3:0] CMD_IO_RD  = 4'b0010;
   localparam logic [3:0] CMD_IO_WR  = 4'b0011;
   localparam logic [3:0] CMD_MEM_RD = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR = 4'b0111;
   localparam logic [3:0] CMD_CFG_RD = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR = 4'b1011;

   // Map a command code to the address space it may target.
   function automatic space_e cmd_family(input logic [3:0] cmd);
      case (cmd)
         CMD_IO_RD,  CMD_IO_WR  : cmd_family = SP_IO;
         CMD_MEM_RD, CMD_MEM_WR : cmd_family = SP_MEM;
         CMD_CFG_RD, CMD_CFG_WR : cmd_family = SP_CFG;
         default                : cmd_family = SP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/addr_phase_det.sv
module addr_phase_det (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic irdy_n,
   output logic addr_phase
);
   logic idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idle_q <= 1'b1;
      else        idle_q <= frame_n & irdy_n;
   end

   assign addr_phase = idle_q & ~frame_n;

   // R2: an address edge is never followed directly by another one
   a_r2_single_sample : assert property (@(posedge clk) disable iff (!rst_n)
      addr_phase |=> !addr_phase);

endmodule

// File: rtl/window_match.sv
module window_match #(
   parameter int ADDR_W   = 32,
   parameter int IGN_BITS = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] ONES = '1;
   localparam logic [ADDR_W-1:0] KEEP = ONES << IGN_BITS;

   generate
      if (IGN_BITS < 0 || IGN_BITS >= ADDR_W) begin : g_bad
         $error("window_match: IGN_BITS out of range");
      end
      if (IGN_BITS == 0) begin : g_exact
         assign hit = (addr == base);
      end else begin : g_masked
         assign hit = ~|((addr ^ base) & KEEP);
      end
   endgenerate

endmodule

// File: rtl/claim_ctrl.sv
module claim_ctrl
   import pci_claim_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   addr_phase,
   input  space_e dec_space,
   input  logic   frame_n,
   input  logic   irdy_n,
   input  logic   trdy_n,
   output logic   devsel_n,
   output space_e space_q,
   output logic   xfer_fire
);
   space_e pend_q;
   logic   claimed_q;
   logic   xfer_q;
   logic   release_now;

   // Last data phase completes, or bus goes idle (abort path).
   assign release_now = frame_n & (irdy_n | ~trdy_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= SP_NONE;
         space_q   <= SP_NONE;
         claimed_q <= 1'b0;
         xfer_q    <= 1'b0;
      end else begin
         xfer_q <= claimed_q & ~irdy_n & ~trdy_n;
         if (release_now) begin
            claimed_q <= 1'b0;
            space_q   <= SP_NONE;
         end else if (pend_q != SP_NONE) begin
            claimed_q <= 1'b1;
            space_q   <= pend_q;
         end
         pend_q <= addr_phase ? dec_space : SP_NONE;
      end
   end

   assign devsel_n  = ~claimed_q;
   assign xfer_fire = xfer_q;

   // R8: a pending decision becomes a claim on the next edge
   a_r8_claim_follows : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q != SP_NONE && !release_now) |=> !devsel_n);

   // R9: the final data phase drops the claim
   a_r9_release_after_last : assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel_n && frame_n && !irdy_n && !trdy_n) |=> devsel_n);

   // R10: a transfer strobe needs both ready lines and a claim one edge earlier
   a_r10_xfer_only_ready : assert property (@(posedge clk) disable iff (!rst_n)
      xfer_fire |-> $past(!irdy_n && !trdy_n && !devsel_n));

   // R11: the space code is non-zero exactly while claimed
   a_r11_space_tracks_devsel : assert property (@(posedge clk) disable iff (!rst_n)
      (space_q != SP_NONE) == !devsel_n);

endmodule

// File: rtl/pci_tgt_claim.sv
module pci_tgt_claim
   import pci_claim_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int IO_IGN_BITS  = 8,
   parameter int MEM_IGN_BITS = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_ad,
   input  logic [3:0]        bus_cbe_n,
   input  logic              bus_frame_n,
   input  logic              bus_irdy_n,
   input  logic              bus_trdy_n,
   input  logic              bus_idsel,
   input  logic [ADDR_W-1:0] io_win_base,
   input  logic [ADDR_W-1:0] mem_win_base,
   input  logic              io_decode_en,
   input  logic              mem_decode_en,
   output logic              devsel_n,
   output logic [1:0]        claim_space,
   output logic              xfer_fire
);
   localparam int IO_MIN  = 2;
   localparam int IO_MAX  = 8;
   localparam int MEM_MIN = 4;

   generate
      if (ADDR_W < 16) begin : g_bad_width
         $error("pci_tgt_claim: ADDR_W must be at least 16");
      end
      if (IO_IGN_BITS < IO_MIN || IO_IGN_BITS > IO_MAX) begin : g_bad_io
         $error("pci_tgt_claim: I/O window must be 4 to 256 bytes");
      end
      if (MEM_IGN_BITS < MEM_MIN || MEM_IGN_BITS >= ADDR_W) begin : g_bad_mem
         $error("pci_tgt_claim: memory window must be at least 16 bytes");
      end
   endgenerate

   logic   addr_phase;
   logic   io_hit;
   logic   mem_hit;
   space_e family;
   space_e dec_space;
   space_e space_q;

   addr_phase_det u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_n    (bus_frame_n),
      .irdy_n     (bus_irdy_n),
      .addr_phase (addr_phase)
   );

   window_match #(.ADDR_W(ADDR_W), .IGN_BITS(IO_IGN_BITS)) u_io_win (
      .addr (bus_ad),
      .base (io_win_base),
      .hit  (io_hit)
   );

   window_match #(.ADDR_W(ADDR_W), .IGN_BITS(MEM_IGN_BITS)) u_mem_win (
      .addr (bus_ad),
      .base (mem_win_base),
      .hit  (mem_hit)
   );

   assign family = cmd_family(bus_cbe_n);

   always_comb begin
      case (family)
         SP_IO   : dec_space = (io_decode_en  && io_hit)  ? SP_IO  : SP_NONE;
         SP_MEM  : dec_space = (mem_decode_en && mem_hit) ? SP_MEM : SP_NONE;
         SP_CFG  : dec_space = (bus_idsel && bus_ad[1:0] == 2'b00) ? SP_CFG : SP_NONE;
         default : dec_space = SP_NONE;
      endcase
   end

   claim_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_phase (addr_phase),
      .dec_space  (dec_space),
      .frame_n    (bus_frame_n),
      .irdy_n     (bus_irdy_n),
      .trdy_n     (bus_trdy_n),
      .devsel_n   (devsel_n),
      .space_q    (space_q),
      .xfer_fire  (xfer_fire)
   );

   assign claim_space = space_q;

   // R7: unsupported commands never lead to a claim two edges later
   a_r7_no_foreign_cmd : assert property (@(posedge clk) disable iff (!rst_n)
      (addr_phase && family == SP_NONE) |=> ##1 devsel_n);

   // R6: disabled I/O decoding blocks I/O claims
   a_r6_io_disabled : assert property (@(posedge clk) disable iff (!rst_n)
      (addr_phase && family == SP_IO && !io_decode_en) |=> ##1 devsel_n);

   // R6: disabled memory decoding blocks memory claims
   a_r6_mem_disabled : assert property (@(posedge clk) disable iff (!rst_n)
      (addr_phase && family == SP_MEM && !mem_decode_en) |=> ##1 devsel_n);

   // R5: configuration needs the slot select
   a_r5_cfg_needs_select : assert property (@(posedge clk) disable iff (!rst_n)
      (addr_phase && family == SP_CFG && !bus_idsel) |=> ##1 devsel_n);

endmodule

// File: tb/sim_pci_tgt_claim.sv
module sim_pci_tgt_claim;
   localparam int AW  = 32;
   localparam int IOI = 4;
   localparam int MMI = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ad = '0;
   logic [3:0]    cbe = 4'h0;
   logic          frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, idsel = 1'b0;
   logic [AW-1:0] io_base = 32'h0000_C140;
   logic [AW-1:0] mem_base = 32'h8004_3000;
   logic          io_en = 1'b1, mem_en = 1'b1;
   logic          devsel_n;
   logic [1:0]    claim_space;
   logic          xfer_fire;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   string cur_req = "R1";

   // reference model state
   int m_prev_idle = 1, m_pend = 0, m_claim = 0, m_space = 0, m_xfer = 0;
   int seen_space = 0, seen_xfer = 0;

   always #10 clk = ~clk;

   pci_tgt_claim #(.ADDR_W(AW), .IO_IGN_BITS(IOI), .MEM_IGN_BITS(MMI)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_ad(ad), .bus_cbe_n(cbe),
      .bus_frame_n(frame_n), .bus_irdy_n(irdy_n), .bus_trdy_n(trdy_n),
      .bus_idsel(idsel), .io_win_base(io_base), .mem_win_base(mem_base),
      .io_decode_en(io_en), .mem_decode_en(mem_en),
      .devsel_n(devsel_n), .claim_space(claim_space), .xfer_fire(xfer_fire)
   );

   function automatic int model_decode();
      int k;
      k = 0;
      case (cbe)
         4'h2, 4'h3: if (io_en && (ad >> IOI) == (io_base >> IOI)) k = 1;
         4'h6, 4'h7: if (mem_en && (ad >> MMI) == (mem_base >> MMI)) k = 2;
         4'hA, 4'hB: if (idsel && ad[1:0] == 2'b00) k = 3;
         default: k = 0;
      endcase
      return k;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prev_idle = 1; m_pend = 0; m_claim = 0; m_space = 0; m_xfer = 0;
      end else begin
         int aphase, rel;
         aphase = (!frame_n && m_prev_idle != 0) ? 1 : 0;
         rel = (frame_n && (irdy_n || !trdy_n)) ? 1 : 0;
         m_xfer = (m_claim != 0 && !irdy_n && !trdy_n) ? 1 : 0;
         if (rel != 0) begin m_claim = 0; m_space = 0; end
         else if (m_pend != 0) begin m_claim = 1; m_space = m_pend; end
         m_pend = (aphase != 0) ? model_decode() : 0;
         m_prev_idle = (frame_n && irdy_n) ? 1 : 0;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      check(cur_req, "devsel_n", int'(devsel_n), (m_claim != 0) ? 0 : 1);
      check(cur_req, "claim_space", int'(claim_space), m_space);
      check(cur_req, "xfer_fire", int'(xfer_fire), m_xfer);
      if (!devsel_n && int'(claim_space) > seen_space) seen_space = int'(claim_space);
      if (xfer_fire) seen_xfer++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog expired actual %0d expected <20000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic txn(input [3:0] cmd, input [AW-1:0] addr, input logic sel,
                      input int ndata, input [AW-1:0] dval, input [3:0] be);
      int got, waits;
      @(negedge clk);
      seen_space = 0; seen_xfer = 0;
      frame_n = 1'b0; ad = addr; cbe = cmd; idsel = sel; irdy_n = 1'b1; trdy_n = 1'b1;
      @(negedge clk);
      ad = dval; cbe = be; idsel = 1'b0; irdy_n = 1'b0;
      frame_n = (ndata == 1); trdy_n = devsel_n;
      got = 0; waits = 0;
      forever begin
         @(negedge clk);
         if (trdy_n == 1'b0) got++; else waits++;
         if (got == ndata) begin
            frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; break;
         end
         if (waits == 5) begin
            frame_n = 1'b1; trdy_n = 1'b1;
            @(negedge clk);
            irdy_n = 1'b1; break;
         end
         if (got == ndata - 1) frame_n = 1'b1;
         trdy_n = devsel_n;
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic expect_txn(input string req, input int sp, input int nx);
      check(req, "space seen", seen_space, sp);
      check(req, "transfers", seen_xfer, nx);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check("R1", "devsel_n in reset", int'(devsel_n), 1);
      check("R1", "claim_space in reset", int'(claim_space), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "xfer_fire after reset", int'(xfer_fire), 0);

      cur_req = "R3";
      txn(4'h2, 32'h0000_C14B, 1'b0, 1, 32'h1234_5678, 4'h0);
      expect_txn("R3", 1, 1);
      txn(4'h3, 32'h0001_C140, 1'b0, 1, 32'h0, 4'h0);   // bit 16 differs
      expect_txn("R3", 0, 0);
      txn(4'h3, 32'h0000_C150, 1'b0, 1, 32'h0, 4'h0);   // just above window
      expect_txn("R3", 0, 0);

      cur_req = "R4";
      txn(4'h6, 32'h8004_3FFD, 1'b0, 3, 32'hDEAD_BEEF, 4'h0);
      expect_txn("R4", 2, 3);
      txn(4'h7, 32'h8004_2000, 1'b0, 1, 32'h0, 4'h0);
      expect_txn("R4", 0, 0);

      cur_req = "R5";
      txn(4'hA, 32'h0000_0A08, 1'b1, 1, 32'h0, 4'h0);
      expect_txn("R5", 3, 1);
      txn(4'hB, 32'h0000_0A09, 1'b1, 1, 32'h0, 4'h0);   // type 1
      expect_txn("R5", 0, 0);
      txn(4'hA, 32'h0000_0A08, 1'b0, 1, 32'h0, 4'h0);   // not selected
      expect_txn("R5", 0, 0);

      cur_req = "R6";
      io_en = 1'b0;
      txn(4'h2, 32'h0000_C140, 1'b0, 1, 32'h0, 4'h0);
      expect_txn("R6", 0, 0);
      io_en = 1'b1; mem_en = 1'b0;
      txn(4'h6, 32'h8004_3000, 1'b0, 1, 32'h0, 4'h0);
      expect_txn("R6", 0, 0);
      mem_en = 1'b1;

      cur_req = "R7";
      for (int c = 0; c < 16; c++) begin
         if (c == 2 || c == 3 || c == 6 || c == 7 || c == 10 || c == 11) continue;
         txn(4'(c), 32'h8004_3000, 1'b1, 1, 32'h0, 4'h0);
         expect_txn("R7", 0, 0);
      end

      cur_req = "R2";
      txn(4'h2, 32'h0000_0000, 1'b0, 3, 32'h8004_3000, 4'h6);
      expect_txn("R2", 0, 0);

      cur_req = "R8";
      @(negedge clk);
      frame_n = 1'b0; ad = 32'h8004_3010; cbe = 4'h7;
      @(negedge clk);
      irdy_n = 1'b0; cbe = 4'h0;
      check("R8", "devsel_n one edge after address", int'(devsel_n), 1);
      @(negedge clk);
      check("R8", "devsel_n two edges after address", int'(devsel_n), 0);
      check("R11", "memory space code", int'(claim_space), 2);
      cur_req = "R9";
      frame_n = 1'b1; trdy_n = 1'b0;
      @(negedge clk);
      check("R9", "devsel_n after last transfer", int'(devsel_n), 1);
      check("R10", "strobe for last transfer", int'(xfer_fire), 1);
      irdy_n = 1'b1; trdy_n = 1'b1;
      @(negedge clk);
      check("R11", "space cleared", int'(claim_space), 0);

      cur_req = "R10";
      seen_xfer = 0;
      @(negedge clk);
      frame_n = 1'b0; ad = 32'h0000_0000; cbe = 4'h2;
      @(negedge clk);
      irdy_n = 1'b0; trdy_n = 1'b0; cbe = 4'h0;
      repeat (2) @(negedge clk);
      frame_n = 1'b1;
      @(negedge clk);
      irdy_n = 1'b1; trdy_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10", "no strobe without claim", seen_xfer, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule